// File: doc/BRIEF.md
# Display Line Interrupt Status Unit

This block holds the interrupt status and mask state of a display controller in one 32-bit register. It records two events in sticky status bits.

- A line-match event sets a status bit when the vertical line counter first becomes equal to a programmed compare line.
- A sync-loss event sets a second status bit when external-sync locking is active, its timeout is enabled, a frame ends, and the external video-valid input is low.

The sync-loss event also pulses a fallback flag. The timing generator uses this flag to start the next frame on its own internal timing.

Software reads the register through a plain read port and writes it through a plain write strobe. A mask bit held at 1 blocks the matching event from the interrupt line, but it never stops the status bit from setting. Each status bit is cleared by writing a 1 to it. The register, its control inputs and its outputs carry no stream data, so every pin is a plain level or strobe with no handshake.

Top module: `disp_line_irq`

## Requirements
- R1: After reset the register reads 0x00000003 (both mask bits set, both status bits clear). `irq_out` and `timing_fallback` are low.
- R2: Bit 16 (line status) becomes 1 after the first rising edge at which `vert_count` equals `line_compare`, whatever the value of bit 0. Further edges with the equality still true do not set it again once it has been cleared. A change of `line_compare` that creates equality also counts as a first match.
- R3: Bit 17 (sync-loss status) becomes 1 after an edge where `frame_end`, `lock_en` and `lock_timeout_en` are all high and `video_valid` is low. If any one of these inputs is out of place, bit 17 stays clear.
- R4: `timing_fallback` is high for exactly the one cycle after each edge that sampled the sync-loss condition of R3, and is low otherwise.
- R5: A write with bit 16 or bit 17 of the write data at 1 clears that status bit. A 0 in that position leaves the bit unchanged. A hardware set in the same cycle as a clear wins.
- R6: Write data bits 0 and 1 load the line mask and the sync-loss mask, where 1 means masked. `irq_out` equals (bit16 AND NOT bit0) OR (bit17 AND NOT bit1), and a mask write affects it from the cycle after the write.
- R7: Bits 31:18 and 15:2 always read as 0, and writing them has no effect.
- R8: A status bit stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle high |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current register contents |
| vert_count | input | LINE_W | Current vertical line number |
| line_compare | input | LINE_W | Programmed compare line |
| frame_end | input | 1 | End-of-frame strobe |
| lock_en | input | 1 | External-sync locking enabled |
| lock_timeout_en | input | 1 | Locking timeout enabled |
| video_valid | input | 1 | External video-valid indication |
| irq_out | output | 1 | Interrupt request, active high |
| timing_fallback | output | 1 | One-cycle request to start the next frame on internal timing |

## Verification
Every result of this block is due one rising edge after the stimulus that causes it. This covers the status bits, mask changes seen on `irq_out`, and the `timing_fallback` pulse. There are no further pipeline stages.

The bench drives each stimulus on a falling edge and samples on the next falling edge, so exactly one capturing edge lies between the two. For the edge-only line match, the bench holds the equality over several following vectors and checks that a clear made during that time stays in effect. Same-cycle set and clear collisions get vectors of their own.

// File: rtl/disp_line_irq_pkg.sv
package disp_line_irq_pkg;
  localparam int REG_W          = 32;
  localparam int NUM_EVT        = 2;
  localparam int EVT_LINE       = 0;
  localparam int EVT_SYNC       = 1;
  localparam int STAT_BASE      = 16;
  localparam int MASK_BASE      = 0;
  localparam logic [NUM_EVT-1:0] MASK_RST = {NUM_EVT{1'b1}};

  function automatic logic [REG_W-1:0] pack_reg(input logic [NUM_EVT-1:0] stat,
                                                input logic [NUM_EVT-1:0] mask);
    logic [REG_W-1:0] r;
    r = '0;
    r[STAT_BASE +: NUM_EVT] = stat;
    r[MASK_BASE +: NUM_EVT] = mask;
    return r;
  endfunction
endpackage

// File: rtl/line_edge_detect.sv
module line_edge_detect #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] count,
  input  logic [LINE_W-1:0] compare,
  output logic              hit
);
  logic eq_now;
  logic eq_prev;

  assign eq_now = (count == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_prev <= 1'b0;
    else        eq_prev <= eq_now;
  end

  // only the first cycle of equality is an event
  assign hit = eq_now & ~eq_prev;
endmodule

// File: rtl/sync_loss_detect.sv
module sync_loss_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic lock_en,
  input  logic lock_timeout_en,
  input  logic video_valid,
  output logic loss,
  output logic fallback
);
  assign loss = frame_end & lock_en & lock_timeout_en & ~video_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fallback <= 1'b0;
    else        fallback <= loss;
  end
endmodule

// File: rtl/sticky_status_bit.sv
module sticky_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;   // set has priority over a software clear
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/disp_line_irq.sv
module disp_line_irq
  import disp_line_irq_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic [LINE_W-1:0] vert_count,
  input  logic [LINE_W-1:0] line_compare,
  input  logic              frame_end,
  input  logic              lock_en,
  input  logic              lock_timeout_en,
  input  logic              video_valid,
  output logic              irq_out,
  output logic              timing_fallback
);
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_clr;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] mask_q;
  logic line_hit;
  logic sync_loss;

  line_edge_detect #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .count(vert_count), .compare(line_compare), .hit(line_hit)
  );

  sync_loss_detect u_sync (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .lock_en(lock_en),
    .lock_timeout_en(lock_timeout_en), .video_valid(video_valid),
    .loss(sync_loss), .fallback(timing_fallback)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EVT_LINE] = line_hit;
    evt_set[EVT_SYNC] = sync_loss;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    assign evt_clr[i] = reg_wr_en & reg_wr_data[STAT_BASE + i];
    sticky_status_bit u_bit (
      .clk(clk), .rst_n(rst_n), .set_i(evt_set[i]), .clr_i(evt_clr[i]), .q(stat_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= MASK_RST;
    else if (reg_wr_en) mask_q <= reg_wr_data[MASK_BASE +: NUM_EVT];
  end

  assign reg_rd_data = pack_reg(stat_q, mask_q);
  assign irq_out     = |(stat_q & ~mask_q);
endmodule

// File: rtl/disp_line_irq_chk.sv
module disp_line_irq_chk #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wr_data,
  input logic [31:0]       reg_rd_data,
  input logic [LINE_W-1:0] vert_count,
  input logic [LINE_W-1:0] line_compare,
  input logic              frame_end,
  input logic              lock_en,
  input logic              lock_timeout_en,
  input logic              video_valid,
  input logic              irq_out,
  input logic              timing_fallback
);
  logic eq_in;
  logic cond_in;
  assign eq_in   = (vert_count == line_compare);
  assign cond_in = frame_end & lock_en & lock_timeout_en & ~video_valid;

  a_r2_line_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_in) |=> reg_rd_data[16]);

  a_r3_sync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cond_in |=> reg_rd_data[17]);

  a_r4_fallback_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cond_in |=> timing_fallback);

  a_r4_fallback_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_in |=> !timing_fallback);

  a_r5_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[17] && !cond_in) |=> !reg_rd_data[17]);

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[0] && reg_wr_data[1]) |=> !irq_out);

  a_r8_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[16] && !(reg_wr_en && reg_wr_data[16])) |=> reg_rd_data[16]);

  a_r8_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[17] && !(reg_wr_en && reg_wr_data[17])) |=> reg_rd_data[17]);
endmodule

bind disp_line_irq disp_line_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data), .vert_count(vert_count), .line_compare(line_compare),
  .frame_end(frame_end), .lock_en(lock_en), .lock_timeout_en(lock_timeout_en),
  .video_valid(video_valid), .irq_out(irq_out), .timing_fallback(timing_fallback)
);

// File: tb/disp_line_irq_bench.sv
module disp_line_irq_bench;
  localparam int LW = 11;

  typedef struct packed {
    logic          we;
    logic [31:0]   wd;
    logic [LW-1:0] vc;
    logic [LW-1:0] cmp;
    logic          fe;
    logic          le;
    logic          te;
    logic          vv;
    logic [31:0]   exp_rd;
    logic          exp_irq;
    logic          exp_fb;
  } vec_t;

  localparam int NV = 18;
  // we, wd, vc, cmp, fe, le, te, vv, exp_rd, exp_irq, exp_fb
  localparam vec_t VT [NV] = '{
    '{1'b0, 32'h0,        11'd5,  11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0003, 1'b0, 1'b0}, // 0 R2 no match
    '{1'b0, 32'h0,        11'd10, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0001_0003, 1'b0, 1'b0}, // 1 R2 sets while masked
    '{1'b1, 32'h0,        11'd10, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0001_0000, 1'b1, 1'b0}, // 2 R6 unmask
    '{1'b1, 32'h0001_0000,11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // 3 R5 clear
    '{1'b0, 32'h0,        11'd10, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0001_0000, 1'b1, 1'b0}, // 4 R2 new match
    '{1'b1, 32'h0001_0000,11'd10, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // 5 R2 held equal, no re-set
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b1,1'b1,1'b1,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // 6 R3 video valid
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b1,1'b1,1'b0,1'b0, 32'h0000_0000, 1'b0, 1'b0}, // 7 R3 no timeout
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b1,1'b0,1'b1,1'b0, 32'h0000_0000, 1'b0, 1'b0}, // 8 R3 no lock
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b0,1'b1,1'b1,1'b0, 32'h0000_0000, 1'b0, 1'b0}, // 9 R3 no frame end
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b1,1'b1,1'b1,1'b0, 32'h0002_0000, 1'b1, 1'b1}, // 10 R3/R4 loss
    '{1'b0, 32'h0,        11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0002_0000, 1'b1, 1'b0}, // 11 R8/R4 sticky, pulse ends
    '{1'b1, 32'h0000_0002,11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0002_0002, 1'b0, 1'b0}, // 12 R6 mask sync
    '{1'b1, 32'h0002_0002,11'd11, 11'd10, 1'b1,1'b1,1'b1,1'b0, 32'h0002_0002, 1'b0, 1'b1}, // 13 R5 set wins
    '{1'b1, 32'h0002_0000,11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // 14 R5 clear sync
    '{1'b1, 32'hFFFC_FFFC,11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // 15 R7 reserved
    '{1'b1, 32'h0001_0000,11'd10, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0001_0000, 1'b1, 1'b0}, // 16 R5 line set wins
    '{1'b1, 32'h0000_0001,11'd11, 11'd10, 1'b0,1'b0,1'b0,1'b1, 32'h0001_0001, 1'b0, 1'b0}  // 17 R6 mask line
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 4, 5:       return "R2";
      6, 7, 8, 9, 10:   return "R3";
      11:               return "R8";
      2, 12, 17:        return "R6";
      15:               return "R7";
      default:          return "R5";
    endcase
  endfunction

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic [LW-1:0] vert_count = '0;
  logic [LW-1:0] line_compare = 11'd10;
  logic          frame_end = 1'b0;
  logic          lock_en = 1'b0;
  logic          lock_timeout_en = 1'b0;
  logic          video_valid = 1'b1;
  logic          irq_out;
  logic          timing_fallback;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  disp_line_irq #(.LINE_W(LW)) u_disp_line_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .vert_count(vert_count), .line_compare(line_compare),
    .frame_end(frame_end), .lock_en(lock_en), .lock_timeout_en(lock_timeout_en),
    .video_valid(video_valid), .irq_out(irq_out), .timing_fallback(timing_fallback)
  );

  task automatic check(input string req, input logic [31:0] exp_rd,
                       input logic exp_irq, input logic exp_fb);
    total++;
    if (reg_rd_data !== exp_rd || irq_out !== exp_irq || timing_fallback !== exp_fb) begin
      bad++;
      $display("FAIL %s: rd=%h irq=%b fb=%b expected rd=%h irq=%b fb=%b",
               req, reg_rd_data, irq_out, timing_fallback, exp_rd, exp_irq, exp_fb);
    end
  endtask

  task automatic idle();
    reg_wr_en = 1'b0; reg_wr_data = '0; frame_end = 1'b0;
    lock_en = 1'b0; lock_timeout_en = 1'b0; video_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0000_0003, 1'b0, 1'b0);
    rst_n = 1'b1;
    vert_count = 11'd5;

    for (int i = 0; i < NV; i++) begin
      reg_wr_en = VT[i].we; reg_wr_data = VT[i].wd;
      vert_count = VT[i].vc; line_compare = VT[i].cmp;
      frame_end = VT[i].fe; lock_en = VT[i].le;
      lock_timeout_en = VT[i].te; video_valid = VT[i].vv;
      @(negedge clk);
      check(tag_of(i), VT[i].exp_rd, VT[i].exp_irq, VT[i].exp_fb);
    end

    // R8: line status stays set over idle cycles
    idle();
    repeat (4) @(negedge clk);
    check("R8", 32'h0001_0001, 1'b0, 1'b0);

    // R2: equality created by a change of the compare line
    reg_wr_en = 1'b1; reg_wr_data = 32'h0001_0000; // clear, unmask all
    @(negedge clk);
    check("R5", 32'h0000_0000, 1'b0, 1'b0);
    idle();
    line_compare = 11'd11;
    @(negedge clk);
    check("R2", 32'h0001_0000, 1'b1, 1'b0);

    // R6: remask takes effect on the cycle after the write
    reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0001;
    @(negedge clk);
    check("R6", 32'h0001_0001, 1'b0, 1'b0);
    idle();

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check("R1", 32'h0000_0003, 1'b0, 1'b0);
    @(negedge clk);
    line_compare = 11'd10; vert_count = 11'd11;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0000_0003, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: rd=%h expected completion", reg_rd_data);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule